// File: doc/BRIEF.md
# Timestamp Record FIFO with Word-Serial Readout

This block queues hardware timestamp records for precision-time event frames on one direction (transmit or receive) of one network port. A capture engine hands over a whole record in one cycle: a 16-bit tag, a 48-bit seconds value, a 32-bit nanoseconds value, a 64-bit clock identity, a 16-bit port number and a 16-bit sequence identifier. Records are kept in arrival order until a processor drains them.

The processor sees two registers behind a small read/write port. Each read of the data register returns the next 16-bit word of the oldest record. The status register carries a capture enable, a read-position counter and a saturating count of records dropped because the queue was full. Software reads the position counter before it starts a record so it can confirm it is aligned on a record boundary. The block also drives its own not-empty flag into a slot of a buffer-status vector that a neighbouring unit ORs across ports and directions.

Top module: `ts_record_fifo`

## Requirements
- R1: After reset the status register reads 16'h0000, the queue is empty, the not-empty flag is low and a data read returns 0.
- R2: A capture push is stored only while the capture enable (status bit 15, set and cleared by writing status bit 15 at address 0) is 1. A push while it is 0 leaves the queue unchanged.
- R3: Reads of the data register (address 1) return each record as 12 words in this order: tag, seconds from most to least significant word (3 words), nanoseconds from most to least significant word (2 words), clock identity from most to least significant word (4 words), port number, sequence identifier. The tag word is returned unchanged; its bits 2:0 hold the message code (1 Sync, 2 peer-delay request, 3 peer-delay response, 4 delay request).
- R4: Status bits 12:8 give the number of words already read from the head record. The value is 0 before the first word of a record. Reading word 11 wraps it to 0 and removes the record.
- R5: Records are read out in the order they were pushed.
- R6: The queue holds DEPTH records (default 90). A push that finds it full is dropped and increments the discard counter at status bits 7:4, which saturates at 15 and is cleared only by reset.
- R7: A data read while the queue is empty returns 0 and leaves the status register unchanged.
- R8: The 2*N_PORTS-bit buffer-status output has one active bit, at index DIR_RX*N_PORTS + PORT_IDX (transmit flags at 0..N_PORTS-1, receive flags above them), which is 1 exactly while the queue is non-empty. All other bits are 0.
- R9: Status register layout: bit 15 capture enable, bits 12:8 read position, bits 7:4 discard count. Bits 14:13 and 3:0 read 0.
- R10: Fullness for a push is judged on the occupancy before any pop in the same cycle, so a push that coincides with the read of the last word of a full queue is dropped and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_valid | input | 1 | Capture push strobe, one record per cycle |
| cap_tag | input | 16 | Tag word, message code in bits 2:0 |
| cap_sec | input | 48 | Seconds field |
| cap_nsec | input | 32 | Nanoseconds field |
| cap_clk_id | input | 64 | Clock identity field |
| cap_port_num | input | 16 | Port number field |
| cap_seq_id | input | 16 | Sequence identifier field |
| bus_addr | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe; bus_rdata updates at the same clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data; only bit 15 of the status register is writable |
| bus_rdata | output | 16 | Read data, registered and held until the next read |
| buf_nonempty | output | 6 | Not-empty flag placed in this instance's slot of the buffer-status vector |

## Verification
The readout path is tried with a table of six records: all-zero fields, all-one fields, alternating bit patterns, walking values and each of the four message codes in the tag. Any swapped word order, lost high word or byte-lane error shows up as a mismatch on a specific word position. Before every word the read position is sampled, which separates a counter that wraps at the wrong count from one that pops too early. A fill-to-capacity run followed by a push that coincides with the final word of the head record distinguishes judging fullness before versus after the pop. Further overflow pushes drive the discard count into saturation, and a full drain checks ordering across the pointer wrap.

// File: rtl/ts_fifo_pkg.sv
package ts_fifo_pkg;

    localparam int WORD_W    = 16;
    localparam int TAG_W     = 16;
    localparam int SEC_W     = 48;
    localparam int NSEC_W    = 32;
    localparam int CLKID_W   = 64;
    localparam int PORTNUM_W = 16;
    localparam int SEQ_W     = 16;

    localparam int REC_W     = TAG_W + SEC_W + NSEC_W + CLKID_W + PORTNUM_W + SEQ_W;
    localparam int REC_WORDS = REC_W / WORD_W;
    localparam int POS_W     = 5;
    localparam int DISC_W    = 4;

    // register select
    localparam logic REG_STATUS = 1'b0;
    localparam logic REG_DATA   = 1'b1;

    // fields declared most significant first: readout order equals bit order
    typedef struct packed {
        logic [TAG_W-1:0]     tag;
        logic [SEC_W-1:0]     sec;
        logic [NSEC_W-1:0]    nsec;
        logic [CLKID_W-1:0]   clk_id;
        logic [PORTNUM_W-1:0] port_num;
        logic [SEQ_W-1:0]     seq_id;
    } ts_rec_t;

    typedef struct packed {
        logic              cap_en;
        logic [1:0]        rsv_hi;
        logic [POS_W-1:0]  pos;
        logic [DISC_W-1:0] disc;
        logic [3:0]        rsv_lo;
    } stat_reg_t;

    typedef enum logic [2:0] {
        MSG_NONE      = 3'd0,
        MSG_SYNC      = 3'd1,
        MSG_PDLY_REQ  = 3'd2,
        MSG_PDLY_RESP = 3'd3,
        MSG_DLY_REQ   = 3'd4
    } msg_code_e;

    // select word idx of a record, word 0 being the most significant
    function automatic logic [WORD_W-1:0] rec_word(input ts_rec_t r,
                                                   input logic [POS_W-1:0] idx);
        logic [REC_W-1:0] flat;
        logic [WORD_W-1:0] w;
        flat = r;
        w = '0;
        for (int i = 0; i < REC_WORDS; i++) begin
            if (idx == POS_W'(i)) w = flat[REC_W-1-WORD_W*i -: WORD_W];
        end
        return w;
    endfunction

endpackage

// File: rtl/ts_rec_store.sv
module ts_rec_store
    import ts_fifo_pkg::*;
#(
    parameter int DEPTH = 90
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  ts_rec_t                        push_rec,
    input  logic                           pop,
    output ts_rec_t                        head_rec,
    output logic                           empty,
    output logic                           full,
    output logic                           push_drop,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH-1);

    ts_rec_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
    // fullness judged on occupancy before this cycle's pop
    assign push_ok   = push && !full;
    assign push_drop = push && full;
    assign pop_ok    = pop && !empty;
    assign head_rec  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_rec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    a_r6_full_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

    a_r5_push_grows: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/ts_word_reader.sv
module ts_word_reader
    import ts_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_rd,
    input  logic              empty,
    input  ts_rec_t           head_rec,
    output logic [POS_W-1:0]  rd_pos,
    output logic [WORD_W-1:0] cur_word,
    output logic              pop
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(REC_WORDS-1);

    logic advance;

    assign advance  = word_rd && !empty;
    assign pop      = advance && (rd_pos == LAST_POS);
    assign cur_word = rec_word(head_rec, rd_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pos <= '0;
        end else if (advance) begin
            rd_pos <= (rd_pos == LAST_POS) ? '0 : rd_pos + 1'b1;
        end
    end

    a_r4_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        rd_pos <= LAST_POS);

    a_r4_wrap_at_last: assert property (@(posedge clk) disable iff (rst)
        (word_rd && !empty && rd_pos == LAST_POS) |=> (rd_pos == '0));

    a_r7_empty_read_holds: assert property (@(posedge clk) disable iff (rst)
        (word_rd && empty) |=> $stable(rd_pos));

endmodule

// File: rtl/ts_stat_ctrl.sv
module ts_stat_ctrl
    import ts_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              push_drop,
    input  logic              empty,
    input  logic [POS_W-1:0]  rd_pos,
    input  logic [WORD_W-1:0] cur_word,
    output logic              cap_en,
    output logic              word_rd,
    output logic [WORD_W-1:0] bus_rdata
);
    logic [DISC_W-1:0] disc;
    stat_reg_t         stat;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[WORD_W-2:0];
    assign word_rd      = bus_rd && (bus_addr == REG_DATA);

    always_comb begin
        stat        = '0;
        stat.cap_en = cap_en;
        stat.pos    = rd_pos;
        stat.disc   = disc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_en    <= 1'b0;
            disc      <= '0;
            bus_rdata <= '0;
        end else begin
            if (bus_wr && bus_addr == REG_STATUS) cap_en <= bus_wdata[WORD_W-1];
            if (push_drop && disc != '1) disc <= disc + 1'b1;
            if (bus_rd) begin
                if (bus_addr == REG_STATUS) bus_rdata <= stat;
                else                        bus_rdata <= empty ? '0 : cur_word;
            end
        end
    end

    a_r6_disc_saturates: assert property (@(posedge clk) disable iff (rst)
        (disc == '1) |=> (disc == '1));

    a_r6_disc_counts_drop: assert property (@(posedge clk) disable iff (rst)
        (push_drop && disc != '1) |=> (disc == $past(disc) + 1'b1));

endmodule

// File: rtl/ts_record_fifo.sv
module ts_record_fifo
    import ts_fifo_pkg::*;
#(
    parameter int DEPTH    = 90,
    parameter int N_PORTS  = 3,
    parameter int PORT_IDX = 1,
    parameter int DIR_RX   = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cap_valid,
    input  logic [TAG_W-1:0]       cap_tag,
    input  logic [SEC_W-1:0]       cap_sec,
    input  logic [NSEC_W-1:0]      cap_nsec,
    input  logic [CLKID_W-1:0]     cap_clk_id,
    input  logic [PORTNUM_W-1:0]   cap_port_num,
    input  logic [SEQ_W-1:0]       cap_seq_id,
    input  logic                   bus_addr,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    output logic [2*N_PORTS-1:0]   buf_nonempty
);
    localparam int FLAG_BIT = DIR_RX * N_PORTS + PORT_IDX;
    localparam int CNT_W    = $clog2(DEPTH+1);

    ts_rec_t           in_rec;
    ts_rec_t           head_rec;
    logic              cap_en;
    logic              push;
    logic              pop;
    logic              empty;
    logic              full;
    logic              push_drop;
    logic              word_rd;
    logic [POS_W-1:0]  rd_pos;
    logic [WORD_W-1:0] cur_word;
    logic [CNT_W-1:0]  count;

    always_comb begin
        in_rec.tag      = cap_tag;
        in_rec.sec      = cap_sec;
        in_rec.nsec     = cap_nsec;
        in_rec.clk_id   = cap_clk_id;
        in_rec.port_num = cap_port_num;
        in_rec.seq_id   = cap_seq_id;
    end

    assign push = cap_valid && cap_en;

    ts_rec_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_rec  (in_rec),
        .pop       (pop),
        .head_rec  (head_rec),
        .empty     (empty),
        .full      (full),
        .push_drop (push_drop),
        .count     (count)
    );

    ts_word_reader u_reader (
        .clk      (clk),
        .rst      (rst),
        .word_rd  (word_rd),
        .empty    (empty),
        .head_rec (head_rec),
        .rd_pos   (rd_pos),
        .cur_word (cur_word),
        .pop      (pop)
    );

    ts_stat_ctrl u_stat (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .push_drop (push_drop),
        .empty     (empty),
        .rd_pos    (rd_pos),
        .cur_word  (cur_word),
        .cap_en    (cap_en),
        .word_rd   (word_rd),
        .bus_rdata (bus_rdata)
    );

    generate
        for (genvar g = 0; g < 2*N_PORTS; g++) begin : g_flag
            if (g == FLAG_BIT) begin : g_own
                assign buf_nonempty[g] = !empty;
            end else begin : g_other
                assign buf_nonempty[g] = 1'b0;
            end
        end
    endgenerate

    a_r2_no_capture_when_off: assert property (@(posedge clk) disable iff (rst)
        (!cap_en) |=> (count <= $past(count)));

    a_r8_flag_after_push: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && cap_en && !full) |=> buf_nonempty[FLAG_BIT]);

    a_r10_drop_on_full_pop: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && cap_en && full && pop) |=> (count == $past(count) - 1'b1));

endmodule

// File: tb/test_ts_record_fifo.sv
module test_ts_record_fifo;
    import ts_fifo_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_valid = 1'b0;
    logic [15:0] cap_tag = '0;
    logic [47:0] cap_sec = '0;
    logic [31:0] cap_nsec = '0;
    logic [63:0] cap_clk_id = '0;
    logic [15:0] cap_port_num = '0;
    logic [15:0] cap_seq_id = '0;
    logic        bus_addr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [5:0]  buf_nonempty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [5:0] FLAG_ON = 6'b010000;

    // record patterns: tag, sec, nsec, clock id, port, seq
    localparam logic [191:0] VEC [6] = '{
        {16'h0001, 48'h0000_0000_0000, 32'h0000_0000, 64'h0, 16'h0000, 16'h0000},
        {16'hFFFA, 48'hFFFF_FFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'hFFFF, 16'hFFFF},
        {16'hA5A2, 48'h5555_AAAA_5555, 32'hAAAA_5555, 64'h0F0F_F0F0_3C3C_C3C3, 16'h1234, 16'hFEDC},
        {16'h0003, 48'h0001_0002_0003, 32'h0004_0005, 64'h0006_0007_0008_0009, 16'h000A, 16'h000B},
        {16'h8004, 48'h8000_0000_0001, 32'h3B9A_C9FF, 64'h0123_4567_89AB_CDEF, 16'h0002, 16'h7FFF},
        {16'h0011, 48'h1000_2000_3000, 32'h4000_5000, 64'h6000_7000_8000_9000, 16'hA000, 16'hB000}
    };

    ts_record_fifo i_ts_record_fifo (
        .clk, .rst, .cap_valid, .cap_tag, .cap_sec, .cap_nsec, .cap_clk_id,
        .cap_port_num, .cap_seq_id, .bus_addr, .bus_rd, .bus_wr, .bus_wdata,
        .bus_rdata, .buf_nonempty
    );

    always #2 clk = ~clk;

    function automatic logic [15:0] exp_word(input ts_rec_t r, input int i);
        case (i)
            0:  return r.tag;
            1:  return r.sec[47:32];
            2:  return r.sec[31:16];
            3:  return r.sec[15:0];
            4:  return r.nsec[31:16];
            5:  return r.nsec[15:0];
            6:  return r.clk_id[63:48];
            7:  return r.clk_id[47:32];
            8:  return r.clk_id[31:16];
            9:  return r.clk_id[15:0];
            10: return r.port_num;
            default: return r.seq_id;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_rec(input ts_rec_t r);
        cap_tag = r.tag; cap_sec = r.sec; cap_nsec = r.nsec;
        cap_clk_id = r.clk_id; cap_port_num = r.port_num; cap_seq_id = r.seq_id;
    endtask

    task automatic push_rec(input ts_rec_t r);
        @(negedge clk);
        set_rec(r); cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    function automatic ts_rec_t seq_rec(input int s);
        ts_rec_t r;
        r.tag = {13'(s), 3'(MSG_SYNC)};
        r.sec = 48'(s * 3);
        r.nsec = 32'(s * 7);
        r.clk_id = 64'(s);
        r.port_num = 16'(s + 1);
        r.seq_id = 16'(s);
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        ts_rec_t r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        bus_read(REG_STATUS, v); check("R1 status", v, 16'h0000);
        check("R1 flag", {10'b0, buf_nonempty}, 16'h0000);
        bus_read(REG_DATA, v); check("R1 data", v, 16'h0000);

        // R2: push while capture disabled is ignored
        push_rec(ts_rec_t'(VEC[2]));
        check("R2 flag stays low", {10'b0, buf_nonempty}, 16'h0000);
        bus_read(REG_DATA, v); check("R2 nothing stored", v, 16'h0000);

        // R9: enable bit readback
        bus_write(REG_STATUS, 16'hFFFF);
        bus_read(REG_STATUS, v); check("R9 status layout", v, 16'h8000);

        // table walk: R3 word order, R4 position, R5 order, R8 flag
        for (int k = 0; k < 6; k++) push_rec(ts_rec_t'(VEC[k]));
        check("R8 flag slot", {10'b0, buf_nonempty}, {10'b0, FLAG_ON});
        for (int k = 0; k < 6; k++) begin
            r = ts_rec_t'(VEC[k]);
            for (int i = 0; i < 12; i++) begin
                bus_read(REG_STATUS, v);
                check("R4 position", v, 16'h8000 | 16'(i << 8));
                bus_read(REG_DATA, v);
                check("R3 R5 word", v, exp_word(r, i));
            end
            bus_read(REG_STATUS, v); check("R4 wrap to zero", v, 16'h8000);
        end
        check("R8 flag clears", {10'b0, buf_nonempty}, 16'h0000);

        // R6 capacity
        for (int s = 0; s < 90; s++) push_rec(seq_rec(s));
        bus_read(REG_STATUS, v); check("R6 ninety accepted", v, 16'h8000);
        for (int i = 0; i < 11; i++) bus_read(REG_DATA, v);
        bus_read(REG_STATUS, v); check("R4 pos eleven", v, 16'h8B00);

        // R10: push with final-word read of full queue is dropped
        @(negedge clk);
        set_rec(seq_rec(500)); cap_valid = 1'b1;
        bus_addr = REG_DATA; bus_rd = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0; bus_rd = 1'b0;
        check("R10 last word", bus_rdata, 16'd0);
        bus_read(REG_STATUS, v); check("R10 drop counted", v, 16'h8010);

        push_rec(seq_rec(501));
        for (int s = 0; s < 16; s++) push_rec(seq_rec(600 + s));
        bus_read(REG_STATUS, v); check("R6 discard saturates", v, 16'h80F0);

        // R5 drain across pointer wrap
        for (int n = 0; n < 90; n++) begin
            r = seq_rec((n < 89) ? n + 1 : 501);
            for (int i = 0; i < 12; i++) begin
                bus_read(REG_DATA, v);
                if (i == 0 || i == 11) check("R5 order", v, exp_word(r, i));
            end
        end
        check("R8 empty after drain", {10'b0, buf_nonempty}, 16'h0000);

        // R7 empty read
        bus_read(REG_DATA, v); check("R7 empty data", v, 16'h0000);
        bus_read(REG_STATUS, v); check("R7 status unchanged", v, 16'h80F0);

        // R2 disable again
        bus_write(REG_STATUS, 16'h0000);
        push_rec(seq_rec(7));
        check("R2 disabled again", {10'b0, buf_nonempty}, 16'h0000);

        // R1 reset clears discard count
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_read(REG_STATUS, v); check("R1 reset clears", v, 16'h0000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule